// File: doc/BRIEF.md
# SPI Register-File Slave with Data Flags

This block connects a host to a bank of 16-bit registers over a four-wire serial link in mode 3 (clock idles high, data changes on the falling edge, captured on the rising edge). The host sends fixed 16-clock frames, most significant bit first. A frame either writes one byte of one register or asks for a read. The word that was asked for is shifted back during the next frame, so reads are pipelined by one frame and the link runs full duplex. The serial pins are brought into the system clock domain through two-flop synchronisers. The system clock must run at least four times faster than the serial clock.

The register space is byte addressed, and each register takes two addresses: the low byte sits at the even address and the high byte at the odd one. Sample words come from the core and are returned with two flags. Bit 15 is a new-data flag, set by each sample update and cleared when the word is read. Bit 14 is an error flag, which is 1 whenever the sticky status register is non-zero. The data sits right-justified below the flags. A command register can clear the status or reset the register state by software. An identifier register returns a fixed value.

Address map (7-bit byte address): output words at 0x00–0x07 (word i at 2i), control registers at 0x10–0x17, status at 0x3C, command at 0x3E, identifier at 0x4A. The serial link is a plain control interface with no back-pressure. The core's sample strobe is a one-cycle pulse that is always accepted.

Top module: `spi_regmap_slave`

## Requirements
- R1: A frame with bit 15 = 1 is a write. Bits 14:8 hold the byte address and bits 7:0 the data. An even address writes the low byte of a control register and an odd address writes the high byte; the other byte is unchanged.
- R2: The response to a read frame is shifted out on MISO, MSB first, during the following frame. A frame that follows a write frame returns 0x0000.
- R3: An output word reads as {new-data, error, data}, with the sample right-justified in bits 13:0 and sign bits kept as sent by the core.
- R4: The new-data flag of every output word is set by a sample-update pulse. It is cleared by a completed read frame addressing that word, so a second read returns bit 15 = 0.
- R5: Bit 14 of every output word is 1 exactly when the status register is non-zero.
- R6: Status bits are sticky: a pulse on a status-set input sets the bit, and the status reads at 0x3C. Writing a byte with bit 4 set to address 0x3E clears all status bits.
- R7: Writing a byte with bit 7 set to address 0x3E clears the control registers, the status, the output data and the new-data flags.
- R8: A read of address 0x4A returns 0x3F51.
- R9: A frame ended by CS rising after 1 to 15 clocks is discarded and sets status bit 3.
- R10: Writes to read-only addresses (output words, status, identifier) have no effect. Reads of unmapped addresses return 0x0000.
- R11: After reset, the control registers and status are zero and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| smp_upd | input | 1 | One-cycle pulse: new samples on smp_data |
| smp_data | input | NOUT*DATA_W | Sample words from core, word 0 in the low bits |
| stat_set | input | 16 | Pulses that set status bits |
| ctl_regs | output | NCTL*16 | Control register contents, register 0 in the low bits |
| stat_word | output | 16 | Current status register |

## Verification
The bench checks the one-frame read pipeline. A design that returned data in the same frame, or that did not zero the reply after a write, would shift a wrong word on MISO. It reads the same output word twice around a sample update. A flag that never cleared, or was cleared by the wrong address, shows up as a wrong bit 15. It sends aborted frames, which must leave the control registers untouched and set status bit 3. A slave that committed partial frames would corrupt a register. It also writes the identifier and output addresses, and it uses the clear and software-reset commands. Decoding errors there would show up as changed read-back values or status bits that stay set.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int FRAME_BITS = 16;
  localparam int ADDR_W     = 7;
  localparam int WIDX_W     = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h3C;
  localparam logic [ADDR_W-1:0] CMD_ADDR  = 7'h3E;
  localparam logic [ADDR_W-1:0] ID_ADDR   = 7'h4A;
  localparam int CTL_WORD   = 8;   // control bank starts at byte 0x10
  localparam logic [15:0] ID_VALUE = 16'h3F51;
  localparam int COMM_ERR_BIT = 3;
  localparam int CMD_CLR_BIT  = 4;
  localparam int CMD_RST_BIT  = 7;

  typedef struct packed {
    logic                 wr;
    logic [ADDR_W-1:0]    addr;
    logic [7:0]           data;
  } frame_t;
endpackage

// File: rtl/srm_sync.sv
module srm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= d[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end
  assign q = sync_q;
endmodule

// File: rtl/srm_frame.sv
module srm_frame
  import srm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_s,
  input  logic        cs_s,
  input  logic        mosi_s,
  input  logic [15:0] tx_word,
  output logic        miso,
  output logic        done,
  output logic        abort,
  output logic [15:0] rx_word
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  logic             sclk_d, cs_d;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      sh_q, rx_q;
  logic             miso_q, done_q, abort_q;

  wire rise    = sclk_s & ~sclk_d;
  wire fall    = ~sclk_s & sclk_d;
  wire cs_fall = ~cs_s & cs_d;
  wire cs_rise = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      cs_d    <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      miso_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      if (cs_fall) begin
        cnt_q  <= '0;
        sh_q   <= tx_word;
        miso_q <= 1'b0;
      end else if (cs_rise) begin
        if (cnt_q != '0 && cnt_q != FULL) abort_q <= 1'b1;
        cnt_q  <= '0;
        miso_q <= 1'b0;
      end else if (!cs_s && cnt_q != FULL) begin
        if (fall) begin
          miso_q <= sh_q[15];
          sh_q   <= {sh_q[14:0], 1'b0};
        end else if (rise) begin
          rx_q  <= {rx_q[14:0], mosi_s};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) done_q <= 1'b1;
        end
      end
    end
  end

  assign miso    = miso_q;
  assign done    = done_q;
  assign abort   = abort_q;
  assign rx_word = rx_q;

  // R2: a frame completion is a single-cycle event
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: a frame can not both complete and abort
  a_r9_done_xor_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && abort_q));
  // R1: the bit counter never passes a full frame
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
endmodule

// File: rtl/srm_regs.sv
module srm_regs
  import srm_pkg::*;
#(
  parameter int NOUT   = 4,
  parameter int DATA_W = 14,
  parameter int NCTL   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done,
  input  logic                   abort,
  input  logic [15:0]            rx_word,
  input  logic                   smp_upd,
  input  logic [NOUT*DATA_W-1:0] smp_data,
  input  logic [15:0]            stat_set,
  output logic [15:0]            tx_word,
  output logic [NCTL*16-1:0]     ctl_flat,
  output logic [15:0]            stat_word
);
  localparam int PAD_W = 14 - DATA_W;

  frame_t            fr;
  logic [WIDX_W-1:0] widx;
  logic              wr_hit, rd_hit, soft_rst, stat_clr, err_flag;
  logic [15:0]       ctl_q [NCTL];
  logic [DATA_W-1:0] dat_q [NOUT];
  logic [NOUT-1:0]   nd_q;
  logic [15:0]       stat_q, tx_q, rd_word;

  assign fr       = frame_t'(rx_word);
  assign widx     = fr.addr[ADDR_W-1:1];
  assign wr_hit   = done & fr.wr;
  assign rd_hit   = done & ~fr.wr;
  assign soft_rst = wr_hit && fr.addr == CMD_ADDR && fr.data[CMD_RST_BIT];
  assign stat_clr = wr_hit && fr.addr == CMD_ADDR && fr.data[CMD_CLR_BIT];
  assign err_flag = |stat_q;

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[g] <= '0;
      else if (soft_rst) ctl_q[g] <= '0;
      else if (wr_hit && widx == WIDX_W'(CTL_WORD + g)) begin
        if (fr.addr[0]) ctl_q[g][15:8] <= fr.data;
        else            ctl_q[g][7:0]  <= fr.data;
      end
    end
    assign ctl_flat[g*16 +: 16] = ctl_q[g];
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[g] <= '0;
        nd_q[g]  <= 1'b0;
      end else if (smp_upd) begin
        dat_q[g] <= smp_data[g*DATA_W +: DATA_W];
        nd_q[g]  <= 1'b1;
      end else if (soft_rst) begin
        dat_q[g] <= '0;
        nd_q[g]  <= 1'b0;
      end else if (rd_hit && widx == WIDX_W'(g)) begin
        nd_q[g]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (soft_rst || stat_clr) stat_q <= stat_set;
    else begin
      stat_q <= stat_q | stat_set;
      if (abort) stat_q[COMM_ERR_BIT] <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NOUT; i++)
      if (widx == WIDX_W'(i))
        rd_word = {nd_q[i], err_flag, {PAD_W{dat_q[i][DATA_W-1]}}, dat_q[i]};
    for (int i = 0; i < NCTL; i++)
      if (widx == WIDX_W'(CTL_WORD + i)) rd_word = ctl_q[i];
    if (widx == STAT_ADDR[ADDR_W-1:1]) rd_word = stat_q;
    if (widx == ID_ADDR[ADDR_W-1:1])   rd_word = ID_VALUE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (done) tx_q <= fr.wr ? 16'h0000 : rd_word;
  end

  assign tx_word   = tx_q;
  assign stat_word = stat_q;

  // R4: every sample update leaves all new-data flags set
  a_r4_nd_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    smp_upd |=> &nd_q);
  // R9: an aborted frame leaves the communication-error bit set
  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> stat_q[COMM_ERR_BIT]);
  // R7: software reset empties the control bank
  a_r7_soft_clears_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ctl_flat == '0);
  // R6: status bits never drop without a clear or soft reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(soft_rst || stat_clr) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R2: a completed write frame queues a zero reply
  a_r2_write_reply_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> tx_word == 16'h0000);
endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave
  import srm_pkg::*;
#(
  parameter int NOUT   = 4,
  parameter int DATA_W = 14,
  parameter int NCTL   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic                   smp_upd,
  input  logic [NOUT*DATA_W-1:0] smp_data,
  input  logic [15:0]            stat_set,
  output logic [NCTL*16-1:0]     ctl_regs,
  output logic [15:0]            stat_word
);
  logic [2:0]  pins_s;
  logic        done, abort;
  logic [15:0] rx_word, tx_word;

  srm_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_mosi, spi_cs_n, spi_sclk}),
    .q     (pins_s)
  );

  srm_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (pins_s[0]),
    .cs_s    (pins_s[1]),
    .mosi_s  (pins_s[2]),
    .tx_word (tx_word),
    .miso    (spi_miso),
    .done    (done),
    .abort   (abort),
    .rx_word (rx_word)
  );

  srm_regs #(.NOUT(NOUT), .DATA_W(DATA_W), .NCTL(NCTL)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .abort     (abort),
    .rx_word   (rx_word),
    .smp_upd   (smp_upd),
    .smp_data  (smp_data),
    .stat_set  (stat_set),
    .tx_word   (tx_word),
    .ctl_flat  (ctl_regs),
    .stat_word (stat_word)
  );

  // R11: MISO stays low while no frame is selected
  a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pins_s[1] && $past(pins_s[1])) |-> !spi_miso);
endmodule

// File: tb/sim_spi_regmap_slave.sv
module sim_spi_regmap_slave;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 80;
  localparam int NOUT = 4, DATA_W = 14, NCTL = 4;

  logic clk = 0, rst_n = 0;
  logic sclk = 1, cs_n = 1, mosi = 0, miso;
  logic smp_upd = 0;
  logic [NOUT*DATA_W-1:0] smp_data = '0;
  logic [15:0] stat_set = '0;
  logic [NCTL*16-1:0] ctl_regs;
  logic [15:0] stat_word;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regmap_slave #(.NOUT(NOUT), .DATA_W(DATA_W), .NCTL(NCTL)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .smp_upd(smp_upd),
    .smp_data(smp_data), .stat_set(stat_set), .ctl_regs(ctl_regs),
    .stat_word(stat_word));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
    cs_n = 0;
    #(SCK_HALF);
    for (int b = 15; b >= 0; b--) begin
      sclk = 0; mosi = tx[b];
      #(SCK_HALF);
      rx[b] = miso;
      sclk = 1;
      #(SCK_HALF);
    end
    cs_n = 1;
    #(SCK_HALF * 2);
  endtask

  function automatic logic [15:0] wrf(input logic [6:0] a, input logic [7:0] d);
    return {1'b1, a, d};
  endfunction
  function automatic logic [15:0] rdf(input logic [6:0] a);
    return {1'b0, a, 8'h00};
  endfunction

  task automatic read_reg(input logic [6:0] a, output logic [15:0] v);
    logic [15:0] dummy;
    xfer(rdf(a), dummy);
    xfer(rdf(7'h30), v);
  endtask

  task automatic pulse_upd(input logic [NOUT*DATA_W-1:0] d);
    @(negedge clk); smp_data = d; smp_upd = 1;
    @(negedge clk); smp_upd = 0;
  endtask

  task automatic pulse_stat(input logic [15:0] s);
    @(negedge clk); stat_set = s;
    @(negedge clk); stat_set = '0;
  endtask

  task automatic t_reset;
    chk("R11 ctl", 64'(ctl_regs), 64'h0);
    chk("R11 stat", 64'(stat_word), 64'h0);
    chk("R11 miso", 64'(miso), 64'h0);
  endtask

  task automatic t_write_read;
    logic [15:0] r, v;
    xfer(wrf(7'h12, 8'hA5), r);
    xfer(wrf(7'h13, 8'h3C), r);
    chk("R2 reply after write", 64'(r), 64'h0);
    chk("R1 byte writes", 64'(ctl_regs[31:16]), 64'h3CA5);
    xfer(wrf(7'h12, 8'h11), r);
    chk("R1 low only", 64'(ctl_regs[31:16]), 64'h3C11);
    read_reg(7'h12, v);
    chk("R2 pipelined read", 64'(v), 64'h3C11);
  endtask

  task automatic t_id_unmapped;
    logic [15:0] r, v;
    read_reg(7'h4A, v);
    chk("R8 id", 64'(v), 64'h3F51);
    xfer(wrf(7'h4A, 8'h00), r);
    xfer(wrf(7'h4B, 8'h00), r);
    read_reg(7'h4A, v);
    chk("R10 id write ignored", 64'(v), 64'h3F51);
    read_reg(7'h30, v);
    chk("R10 unmapped read", 64'(v), 64'h0);
  endtask

  task automatic t_out_flags;
    logic [15:0] r, v;
    logic [NOUT*DATA_W-1:0] d = '0;
    d[1*DATA_W +: DATA_W] = 14'h3FFE;
    d[2*DATA_W +: DATA_W] = 14'h0E0F;
    pulse_upd(d);
    xfer(wrf(7'h02, 8'h55), r);
    read_reg(7'h02, v);
    chk("R3 R4 R10 word1 first read", 64'(v), 64'hBFFE);
    read_reg(7'h02, v);
    chk("R4 word1 flag cleared", 64'(v), 64'h3FFE);
    read_reg(7'h04, v);
    chk("R4 word2 still new", 64'(v), 64'h8E0F);
    pulse_upd(d);
    read_reg(7'h02, v);
    chk("R4 set again", 64'(v), 64'hBFFE);
  endtask

  task automatic t_status;
    logic [15:0] r, v;
    pulse_stat(16'h0001);
    chk("R6 sticky", 64'(stat_word), 64'h0001);
    read_reg(7'h04, v);
    chk("R5 err flag", 64'(v[14]), 64'h1);
    read_reg(7'h3C, v);
    chk("R6 status read", 64'(v), 64'h0001);
    xfer(wrf(7'h3C, 8'h00), r);
    chk("R10 status write ignored", 64'(stat_word), 64'h0001);
    xfer(wrf(7'h3E, 8'h10), r);
    chk("R6 clear", 64'(stat_word), 64'h0);
    read_reg(7'h04, v);
    chk("R5 err flag low", 64'(v[14]), 64'h0);
  endtask

  task automatic t_abort;
    cs_n = 0;
    #(SCK_HALF);
    for (int b = 0; b < 5; b++) begin
      sclk = 0; mosi = 1;
      #(SCK_HALF);
      sclk = 1;
      #(SCK_HALF);
    end
    cs_n = 1;
    #(SCK_HALF * 2);
    chk("R9 abort status", 64'(stat_word), 64'h0008);
    chk("R9 ctl untouched", 64'(ctl_regs[31:16]), 64'h3C11);
  endtask

  task automatic t_soft_reset;
    logic [15:0] r, v;
    xfer(wrf(7'h3E, 8'h80), r);
    chk("R7 ctl cleared", 64'(ctl_regs), 64'h0);
    chk("R7 status cleared", 64'(stat_word), 64'h0);
    read_reg(7'h04, v);
    chk("R7 output cleared", 64'(v), 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 5 + 3);
    rst_n = 1;
    #(CLK_PERIOD * 5);
    t_reset();
    t_write_read();
    t_id_unmapped();
    t_out_flags();
    t_status();
    t_abort();
    t_soft_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule